// File: doc/BRIEF.md
# Four-Channel Simultaneous-Sampling Conversion Sequencer

This block is the digital control side of a four-channel converter that samples all inputs at one instant and then digitizes them one at a time. A rising edge on the convert-start input freezes the set of channels to convert. It raises the busy flag. It then runs a mock conversion of a fixed number of conversion-clock ticks on each chosen channel, lowest index first. At the end of each conversion it stores the per-channel stub value into that channel's result register. The analog front end and the real quantizer are not part of this block. The result values come from the `res_in` stub bus.

Channels are chosen in one of two ways. In pin mode (`hs_sel` low), the `sel_pins` inputs choose the channels and conversion runs off an internal divided clock. In register mode (`hs_sel` high), a channel-select register chooses them. That register is written over a small parallel bus with `cs_n`, `wr_n` and `din`. In register mode, `clk_src` can also switch the conversion clock to the external `ext_clk` input.

Results are read through a pointer that visits only the channels converted in the last run, and `first_data` marks when that pointer is on channel 1. The read port has no back-pressure. The host owns the timing. `dout_vld` qualifies `dout` and is high only while `cs_n` and `rd_n` are both low. The pointer moves on when the host ends the read by raising `rd_n`. A low level on `stby_n` holds the block in a power-save state.

Top module: `simsamp_seq`

## Requirements
- R1: A rising edge on `conv_start`, seen while the block is idle and `stby_n` is high, makes `busy` high on the next clock. On that same clock the block captures the channel set and the clock-source choice.
- R2: With the internal clock, one conversion tick occurs every INT_DIV clocks. `busy` stays high for exactly (number of selected channels) x CONV_TICKS x INT_DIV clocks, then falls.
- R3: Selected channels convert in ascending index order. At the end of a channel's last tick, its result register loads slice k of `res_in` (bits k*RES_W up to k*RES_W+RES_W-1) for channel index k.
- R4: A rising edge on `wr_n` loads `din` into the channel-select register if `cs_n` is low and `rd_n` is high at that edge. Bit k of `din` includes channel index k. A rising edge with `rd_n` low or `cs_n` high has no effect. After reset the register is all ones.
- R5: When `hs_sel` is low, `sel_pins` chooses the channels (bit k = 1 includes channel index k). In this mode the internal clock is used whatever the value of `clk_src`. When `hs_sel` is high, the channel-select register chooses the channels.
- R6: When `hs_sel` is high and `clk_src` is high, each conversion tick comes from one rising edge of `ext_clk`, after a two-stage synchronizer.
- R7: `dout_vld` is high and `dout` carries the addressed result only while `cs_n` and `rd_n` are both low. At all other times both are zero.
- R8: `first_data` is high exactly when the read pointer addresses channel index 0. After reset the pointer is at index 0.
- R9: At a convert start, the read pointer moves to the lowest selected channel. Each read that completes (a rising edge on `rd_n` while `cs_n` is low) moves the pointer to the next higher selected channel, wrapping to the lowest one.
- R10: While `stby_n` is low, convert-start edges are ignored and any conversion in progress pauses. A conversion paused for N clocks ends N clocks later.
- R11: A convert-start edge that arrives while `busy` is high is ignored. It neither restarts nor lengthens the conversion.
- R12: If no channel is selected at convert start, `busy` is high for one clock only. No result register changes, and the read pointer goes to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Convert-start strobe, rising-edge active |
| busy | output | 1 | High while a conversion run is in progress |
| cs_n | input | 1 | Active-low chip select for the read and write bus |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, loads on its rising edge |
| din | input | NCH | Channel-select write data |
| hs_sel | input | 1 | 0 = pin selection with internal clock, 1 = register selection |
| clk_src | input | 1 | In register mode: 0 = internal clock, 1 = `ext_clk` |
| ext_clk | input | 1 | External conversion clock |
| sel_pins | input | NCH | Per-channel include pins used in pin mode |
| stby_n | input | 1 | Low = power-save, high = normal operation |
| res_in | input | NCH*RES_W | Stub conversion values, one slice per channel |
| dout | output | RES_W | Addressed result while a read is active |
| dout_vld | output | 1 | Qualifies `dout` |
| first_data | output | 1 | High when the read pointer is on channel index 0 |

## Verification
The bench builds the block with four channels, 14-bit results and 16 ticks per conversion. It sets INT_DIV to 3 rather than the default, so that an exact busy length of 48 clocks per channel shows that the divider works and is not a pass-through. The external clock is driven at one rising edge per eight system clocks, which separates it clearly from the internal rate. Single-channel, two-channel, four-channel and empty selections are all used. Together these cover the wrap of the read pointer, the skipping of unselected channels, a paused conversion and the one-clock empty run.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EMPTY = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/simsamp_tick.sv
module simsamp_tick #(
  parameter int INT_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic use_ext,
  input  logic ext_clk,
  output logic tick
);
  localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(INT_DIV - 1);

  logic [DW-1:0] div_cnt;
  logic [2:0]    ext_sync;
  logic          int_hit;
  logic          ext_rise;

  assign int_hit  = (div_cnt == DIV_LAST);
  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign tick     = en & (use_ext ? ext_rise : int_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], ext_clk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (restart) begin
      div_cnt <= '0;
    end else if (en && !use_ext) begin
      div_cnt <= int_hit ? '0 : div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/simsamp_core.sv
module simsamp_core
  import simsamp_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CONV_TICKS = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_req,
  input  logic           stby_n,
  input  logic [NCH-1:0] sel_in,
  input  logic           tick,
  output logic           busy,
  output logic           running,
  output logic           start_fire,
  output logic [NCH-1:0] sel_lat,
  output logic [NCH-1:0] store_en
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(CONV_TICKS - 1);

  seq_state_e    state;
  logic [CW-1:0] ch_idx;
  logic [TW-1:0] tick_cnt;
  logic [CW-1:0] first_idx;
  logic [CW-1:0] nxt_idx;
  logic          nxt_found;
  logic          ch_done;

  assign busy       = (state != ST_IDLE);
  assign running    = (state == ST_CONV);
  assign start_fire = start_req & stby_n & (state == ST_IDLE);
  assign ch_done    = running & tick & (tick_cnt == TICK_LAST);

  // lowest selected channel of the incoming set
  always_comb begin
    first_idx = '0;
    for (int j = NCH - 1; j >= 0; j--) begin
      if (sel_in[j]) first_idx = CW'(j);
    end
  end

  // lowest latched channel above the current one
  always_comb begin
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int j = NCH - 1; j >= 0; j--) begin
      if (sel_lat[j] && (j > int'(ch_idx))) begin
        nxt_found = 1'b1;
        nxt_idx   = CW'(j);
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_store
    assign store_en[k] = ch_done & (ch_idx == CW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sel_lat  <= '0;
      ch_idx   <= '0;
      tick_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_fire) begin
            sel_lat  <= sel_in;
            ch_idx   <= first_idx;
            tick_cnt <= '0;
            state    <= (|sel_in) ? ST_CONV : ST_EMPTY;
          end
        end
        ST_EMPTY: state <= ST_IDLE;
        ST_CONV: begin
          if (tick) begin
            if (tick_cnt == TICK_LAST) begin
              tick_cnt <= '0;
              if (nxt_found) ch_idx <= nxt_idx;
              else           state  <= ST_IDLE;
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> busy);

  p_retrigger_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req) |=> $stable(sel_lat));

  p_empty_one_clock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EMPTY) |=> !busy);

  p_store_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_en));

  p_store_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|store_en) |-> (|(store_en & sel_lat)));

endmodule

// File: rtl/simsamp_bank.sv
module simsamp_bank #(
  parameter int NCH   = 4,
  parameter int RES_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     store_en,
  input  logic [NCH*RES_W-1:0] res_in,
  input  logic               start_fire,
  input  logic [NCH-1:0]     sel_new,
  input  logic [NCH-1:0]     sel_lat,
  input  logic               rd_done,
  input  logic               cs_n,
  input  logic               rd_n,
  output logic [RES_W-1:0]   dout,
  output logic               dout_vld,
  output logic               first_data
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [RES_W-1:0] res_q [NCH];
  logic [CW-1:0]    ptr_q;
  logic [CW-1:0]    start_ptr;
  logic [CW-1:0]    hi_ptr;
  logic [CW-1:0]    lo_ptr;
  logic             hi_found;
  logic             lo_found;
  logic [CW-1:0]    adv_ptr;

  for (genvar k = 0; k < NCH; k++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[k] <= '0;
      end else if (store_en[k]) begin
        res_q[k] <= res_in[k*RES_W +: RES_W];
      end
    end
  end

  always_comb begin
    start_ptr = '0;
    hi_found  = 1'b0;
    hi_ptr    = '0;
    lo_found  = 1'b0;
    lo_ptr    = '0;
    for (int j = NCH - 1; j >= 0; j--) begin
      if (sel_new[j]) start_ptr = CW'(j);
      if (sel_lat[j]) begin
        lo_found = 1'b1;
        lo_ptr   = CW'(j);
      end
      if (sel_lat[j] && (j > int'(ptr_q))) begin
        hi_found = 1'b1;
        hi_ptr   = CW'(j);
      end
    end
    adv_ptr = hi_found ? hi_ptr : (lo_found ? lo_ptr : ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (start_fire) begin
      ptr_q <= start_ptr;
    end else if (rd_done) begin
      ptr_q <= adv_ptr;
    end
  end

  assign dout_vld   = ~cs_n & ~rd_n;
  assign dout       = dout_vld ? res_q[ptr_q] : '0;
  assign first_data = (ptr_q == '0);

  p_ptr_on_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_lat) |-> sel_lat[ptr_q]);

  p_ptr_hold_without_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_fire && !rd_done) |=> $stable(ptr_q));

endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq #(
  parameter int NCH        = 4,
  parameter int RES_W      = 14,
  parameter int CONV_TICKS = 16,
  parameter int INT_DIV    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_start,
  output logic                 busy,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [NCH-1:0]       din,
  input  logic                 hs_sel,
  input  logic                 clk_src,
  input  logic                 ext_clk,
  input  logic [NCH-1:0]       sel_pins,
  input  logic                 stby_n,
  input  logic [NCH*RES_W-1:0] res_in,
  output logic [RES_W-1:0]     dout,
  output logic                 dout_vld,
  output logic                 first_data
);
  logic           cv_q, wr_q, rd_q;
  logic           conv_rise, wr_load, rd_done;
  logic [NCH-1:0] chsel_q;
  logic [NCH-1:0] sel_now;
  logic           use_ext_q;
  logic           start_fire;
  logic           running;
  logic           tick;
  logic [NCH-1:0] sel_lat;
  logic [NCH-1:0] store_en;

  assign conv_rise = conv_start & ~cv_q;
  assign wr_load   = wr_n & ~wr_q & ~cs_n & rd_n;
  assign rd_done   = rd_n & ~rd_q & ~cs_n;
  assign sel_now   = hs_sel ? chsel_q : sel_pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b0;
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      cv_q <= conv_start;
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chsel_q <= '1;
    end else if (wr_load) begin
      chsel_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_ext_q <= 1'b0;
    end else if (start_fire) begin
      use_ext_q <= hs_sel & clk_src;
    end
  end

  simsamp_core #(
    .NCH        (NCH),
    .CONV_TICKS (CONV_TICKS)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (conv_rise),
    .stby_n     (stby_n),
    .sel_in     (sel_now),
    .tick       (tick),
    .busy       (busy),
    .running    (running),
    .start_fire (start_fire),
    .sel_lat    (sel_lat),
    .store_en   (store_en)
  );

  simsamp_tick #(
    .INT_DIV (INT_DIV)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (running & stby_n),
    .restart (start_fire),
    .use_ext (use_ext_q),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  simsamp_bank #(
    .NCH   (NCH),
    .RES_W (RES_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_en   (store_en),
    .res_in     (res_in),
    .start_fire (start_fire),
    .sel_new    (sel_now),
    .sel_lat    (sel_lat),
    .rd_done    (rd_done),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .dout       (dout),
    .dout_vld   (dout_vld),
    .first_data (first_data)
  );

  p_standby_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |-> !tick);

  p_standby_no_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_n && !busy) |=> !busy);

  p_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!dout_vld && (dout == '0)));

  p_no_store_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|store_en) |-> busy);

endmodule

// File: tb/tb_simsamp_seq.sv
module tb_simsamp_seq;
  localparam int NCH = 4;
  localparam int RW  = 14;
  localparam int CT  = 16;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [NCH-1:0] din = '0;
  logic hs_sel = 1'b0, clk_src = 1'b0, ext_clk = 1'b0;
  logic [NCH-1:0] sel_pins = '0;
  logic stby_n = 1'b1;
  logic [NCH*RW-1:0] res_in = '0;
  logic busy;
  logic [RW-1:0] dout;
  logic dout_vld, first_data;
  bit ext_run = 1'b0;

  int checks = 0;
  int errors = 0;

  simsamp_seq #(.NCH(NCH), .RES_W(RW), .CONV_TICKS(CT), .INT_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .busy(busy),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .din(din), .hs_sel(hs_sel),
    .clk_src(clk_src), .ext_clk(ext_clk), .sel_pins(sel_pins), .stby_n(stby_n),
    .res_in(res_in), .dout(dout), .dout_vld(dout_vld), .first_data(first_data));

  always #10 clk = ~clk;

  initial begin
    forever begin
      repeat (4) @(negedge clk);
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  function automatic logic [RW-1:0] val(input int set, input int k);
    return RW'(set * 16'h0400 + k * 16'h0111 + 16'h0023);
  endfunction

  task automatic load_set(input int set);
    for (int k = 0; k < NCH; k++) res_in[k*RW +: RW] = val(set, k);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int pause_at, input int pause_len, input bit retrig,
                          output int cnt);
    int guard;
    guard = 0;
    cnt = 0;
    conv_start = 1'b1;
    @(negedge clk);
    chk("R1 busy one clock after start", int'(busy), 1);
    while (busy && guard < 5000) begin
      cnt++;
      if (cnt == 2) conv_start = 1'b0;
      if (retrig && cnt == 8) conv_start = 1'b1;
      if (retrig && cnt == 10) conv_start = 1'b0;
      if (pause_len > 0 && cnt == pause_at) stby_n = 1'b0;
      if (pause_len > 0 && cnt == pause_at + pause_len) stby_n = 1'b1;
      @(negedge clk);
      guard++;
    end
    conv_start = 1'b0;
  endtask

  task automatic read_one(output logic [RW-1:0] d, output bit v, output bit fd);
    fd = first_data;
    cs_n = 1'b0;
    rd_n = 1'b0;
    @(negedge clk);
    d = dout;
    v = dout_vld;
    rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [NCH-1:0] d, input bit cs_low, input bit rd_low);
    cs_n = ~cs_low;
    rd_n = ~rd_low;
    din = d;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy low after reset", int'(busy), 0);
    chk("R8 first_data high after reset", int'(first_data), 1);
    chk("R7 dout_vld low after reset", int'(dout_vld), 0);
    chk("R7 dout zero after reset", int'(dout), 0);
  endtask

  task automatic t_pins_all();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b0; clk_src = 1'b0; sel_pins = 4'b1111;
    load_set(1);
    run_conv(0, 0, 1'b0, cnt);
    chk("R2 busy length four channels", cnt, 4 * CT * DIV);
    for (int k = 0; k < NCH; k++) begin
      read_one(d, v, fd);
      chk("R3 result of channel", int'(d), int'(val(1, k)));
      chk("R7 dout_vld during read", int'(v), 1);
      chk("R8 first_data on pointer", int'(fd), (k == 0) ? 1 : 0);
    end
    read_one(d, v, fd);
    chk("R9 pointer wraps to lowest", int'(d), int'(val(1, 0)));
    chk("R8 first_data after wrap", int'(fd), 1);
  endtask

  task automatic t_pins_sparse();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b0; clk_src = 1'b1; sel_pins = 4'b1010;
    load_set(2);
    run_conv(0, 0, 1'b0, cnt);
    chk("R5 pin mode uses internal clock", cnt, 2 * CT * DIV);
    chk("R9 pointer at lowest selected", int'(first_data), 0);
    read_one(d, v, fd);
    chk("R9 first read channel 1", int'(d), int'(val(2, 1)));
    read_one(d, v, fd);
    chk("R9 skip to channel 3", int'(d), int'(val(2, 3)));
    read_one(d, v, fd);
    chk("R9 wrap to channel 1", int'(d), int'(val(2, 1)));
    clk_src = 1'b0;
  endtask

  task automatic t_register_write();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b1; clk_src = 1'b0; sel_pins = 4'b0001;
    bus_write(4'b0110, 1'b1, 1'b0);
    bus_write(4'b1111, 1'b1, 1'b1);
    bus_write(4'b1001, 1'b0, 1'b0);
    load_set(3);
    run_conv(0, 0, 1'b0, cnt);
    chk("R4 register selects two channels", cnt, 2 * CT * DIV);
    read_one(d, v, fd);
    chk("R4 R5 first channel from register", int'(d), int'(val(3, 1)));
    chk("R8 first_data low on channel 1 index", int'(fd), 0);
    read_one(d, v, fd);
    chk("R4 second channel from register", int'(d), int'(val(3, 2)));
  endtask

  task automatic t_ext_clock();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b1; clk_src = 1'b1;
    ext_run = 1'b1;
    load_set(4);
    run_conv(0, 0, 1'b0, cnt);
    ext_run = 1'b0;
    checks++;
    if (cnt < 2 * CT * 8 - 8 || cnt > 2 * CT * 8 + 8) begin
      errors++;
      $display("FAIL R6: actual=%0d expected=%0d (+/-8)", cnt, 2 * CT * 8);
    end
    read_one(d, v, fd);
    chk("R6 result via external clock", int'(d), int'(val(4, 1)));
    clk_src = 1'b0;
  endtask

  task automatic t_read_quiet();
    cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    chk("R7 no data with rd_n high", int'(dout_vld), 0);
    chk("R7 dout zero with rd_n high", int'(dout), 0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R7 no data with cs_n high", int'(dout_vld), 0);
    chk("R7 dout zero with cs_n high", int'(dout), 0);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_retrigger();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b0; sel_pins = 4'b0001;
    load_set(5);
    run_conv(0, 0, 1'b1, cnt);
    chk("R11 retrigger does not extend busy", cnt, CT * DIV);
    read_one(d, v, fd);
    chk("R11 result after retrigger", int'(d), int'(val(5, 0)));
  endtask

  task automatic t_standby();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b0; sel_pins = 4'b0001;
    load_set(6);
    stby_n = 1'b0;
    @(negedge clk);
    conv_start = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 start ignored in standby", int'(busy), 0);
    conv_start = 1'b0;
    @(negedge clk);
    stby_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 still idle after standby", int'(busy), 0);
    run_conv(10, 20, 1'b0, cnt);
    chk("R10 pause stretches busy", cnt, CT * DIV + 20);
    read_one(d, v, fd);
    chk("R10 result after pause", int'(d), int'(val(6, 0)));
  endtask

  task automatic t_empty();
    int cnt;
    logic [RW-1:0] d;
    bit v, fd;
    hs_sel = 1'b0; sel_pins = 4'b0000;
    load_set(7);
    run_conv(0, 0, 1'b0, cnt);
    chk("R12 empty run busy one clock", cnt, 1);
    chk("R12 pointer at index 0", int'(first_data), 1);
    read_one(d, v, fd);
    chk("R12 results unchanged", int'(d), int'(val(6, 0)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pins_all();
    t_pins_sparse();
    t_register_write();
    t_ext_clock();
    t_read_quiet();
    t_retrigger();
    t_standby();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule